// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block gathers interrupt requests from a set of sources and picks one of them to offer to the processor core. Each source has a 16-bit control word that software reads and writes over a simple register port. The word holds a pending flag, an enable bit, a 4-bit priority level and a 3-bit group level. A hardware request pulse on a source's input sets its pending flag. Software may also set or clear the flag directly.

The arbiter compares every source that is both enabled and pending. The highest level wins. A tie on level goes to the higher group level, and a tie that remains goes to the lowest source index. The winner is offered to the core only if its level is strictly above the core's current priority. The offer is a valid/ready stream: `irq_valid` is the valid signal and `irq_ack` is the ready signal. A handshake happens on a clock edge where both are high. It clears the winner's pending flag. While `irq_ack` stays low the offer is held pending and nothing is cleared. The offer may still be replaced, without a handshake, by a stronger source that becomes eligible. A trap or break request never enters the comparison. It goes straight to the core and suppresses the interrupt offer.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every control word reads 0x0000.
- R2: Bits 15:9 of every control word read 0, whatever value was written to them.
- R3: A write to an address below N_SRC replaces bits 8:0 of that word in one cycle. A read shows the word at once. An address at or above N_SRC reads 0 and ignores writes.
- R4: A high `hw_req[i]` sets bit 7 (pending flag) of word i on the next edge.
- R5: A source with bit 6 (enable) at 0 never wins, even when it is pending.
- R6: The winner has the largest level, taken from bits 5:2, where 0xF is the strongest.
- R7: Among sources of equal level, the larger group level {bit 8, bits 1:0} wins. Any remaining tie goes to the lowest index.
- R8: `irq_valid` is high only when the winner's level is strictly greater than `cpu_lvl`. A level of 0 never produces an offer.
- R9: A handshake clears the winner's pending flag on that edge. If `hw_req` for the same source is high in that cycle, the flag stays set. A register write to the same word is applied first, then the clear, then the hardware set.
- R10: `arb_active` is high exactly when some source is both enabled and pending. When it is low, `irq_valid` is low.
- R11: `trap_out` follows `trap_in` without delay. While `trap_in` is high, `irq_valid` is low.
- R12: While `irq_valid` is high and `irq_ack` is low, no pending flag is cleared. The offered index follows the current winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W | Register index for both reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word (combinational) |
| hw_req | input | N_SRC | Hardware request lines, one per source |
| cpu_lvl | input | 4 | Current core priority level |
| trap_in | input | 1 | Trap or break request |
| trap_out | output | 1 | Trap or break request passed to the core |
| irq_valid | output | 1 | Interrupt offer valid |
| irq_ack | input | 1 | Core accepts the offer (ready) |
| irq_idx | output | IDX_W | Index of the offered source |
| irq_lvl | output | 4 | Priority level of the offered source |
| irq_grp | output | 3 | Group level of the offered source |
| arb_active | output | 1 | Some enabled source is pending |

## Verification
The bench builds the block with N_SRC = 5. With five sources the 3-bit address has three values with no word behind them, so reads of absent words and writes to them are exercised. The small source count also makes ties on level and group level frequent when control words are random, which tests both the group rule and the lowest-index rule. A directed phase covers the cases that are rare at random: a handshake and a hardware set landing on the same edge, a held offer, and a trap arriving during an offer.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int WORD_W  = 16;
  localparam int LVL_W   = 4;
  localparam int GRP_W   = 3;
  localparam int KEY_W   = LVL_W + GRP_W;
  localparam int FLAG_B  = 7;
  localparam int EN_B    = 6;
  localparam int GPX_B   = 8;
  localparam logic [WORD_W-1:0] CTRL_MASK = 16'h01FF;

  typedef logic [WORD_W-1:0] ctrl_word_t;

  function automatic logic [LVL_W-1:0] word_lvl(input ctrl_word_t w);
    return w[5:2];
  endfunction

  function automatic logic [GRP_W-1:0] word_grp(input ctrl_word_t w);
    return {w[GPX_B], w[1:0]};
  endfunction
endpackage

// File: rtl/irq_ctrl_word.sv
module irq_ctrl_word
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  ctrl_word_t wr_data,
  input  logic       hw_set,
  input  logic       ack_clr,
  output ctrl_word_t word_q
);
  ctrl_word_t word_d;

  // order: software write, then handshake clear, then hardware set
  always_comb begin
    word_d = word_q;
    if (wr_en)   word_d = wr_data & CTRL_MASK;
    if (ack_clr) word_d[FLAG_B] = 1'b0;
    if (hw_set)  word_d[FLAG_B] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]            cand,
  input  logic [N_SRC-1:0][KEY_W-1:0] key,
  output logic                        any,
  output logic [IDX_W-1:0]            win_idx,
  output logic [KEY_W-1:0]            win_key
);
  // strict comparison while scanning upward keeps the lowest index on ties
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_key = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!any || key[i] > win_key)) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        win_key = key[i];
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic [N_SRC-1:0] hw_req,
  input  logic [3:0]       cpu_lvl,
  input  logic             trap_in,
  output logic             trap_out,
  output logic             irq_valid,
  input  logic             irq_ack,
  output logic [IDX_W-1:0] irq_idx,
  output logic [3:0]       irq_lvl,
  output logic [2:0]       irq_grp,
  output logic             arb_active
);
  ctrl_word_t                  words   [N_SRC];
  logic [N_SRC-1:0]            flag_vec;
  logic [N_SRC-1:0]            en_vec;
  logic [N_SRC-1:0]            cand;
  logic [N_SRC-1:0][KEY_W-1:0] keys;
  logic [KEY_W-1:0]            win_key;
  logic                        hshake;

  assign hshake = irq_valid && irq_ack;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_ctrl_word u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we && (reg_addr == IDX_W'(g))),
      .wr_data (reg_wdata),
      .hw_set  (hw_req[g]),
      .ack_clr (hshake && (irq_idx == IDX_W'(g))),
      .word_q  (words[g])
    );
    assign flag_vec[g] = words[g][FLAG_B];
    assign en_vec[g]   = words[g][EN_B];
    assign cand[g]     = flag_vec[g] && en_vec[g];
    assign keys[g]     = {word_lvl(words[g]), word_grp(words[g])};
  end

  irq_arb_select #(.N_SRC(N_SRC)) u_sel (
    .cand    (cand),
    .key     (keys),
    .any     (arb_active),
    .win_idx (irq_idx),
    .win_key (win_key)
  );

  assign irq_lvl   = win_key[KEY_W-1:GRP_W];
  assign irq_grp   = win_key[GRP_W-1:0];
  assign irq_valid = arb_active && (irq_lvl > cpu_lvl) && !trap_in;
  assign trap_out  = trap_in;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_SRC; i++)
      if (reg_addr == IDX_W'(i)) reg_rdata = words[i];
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_addr,
  input logic [15:0]      reg_rdata,
  input logic [N_SRC-1:0] hw_req,
  input logic [3:0]       cpu_lvl,
  input logic             trap_in,
  input logic             trap_out,
  input logic             irq_valid,
  input logic             irq_ack,
  input logic [IDX_W-1:0] irq_idx,
  input logic [3:0]       irq_lvl,
  input logic             arb_active,
  input logic [N_SRC-1:0] flag_vec,
  input logic [N_SRC-1:0] en_vec
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:9] == 7'd0);

  // R4
  hw_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_req) |=> ((flag_vec & $past(hw_req)) == $past(hw_req)));

  // R5
  winner_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (en_vec[irq_idx] && flag_vec[irq_idx]));

  // R8
  level_above_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_lvl > cpu_lvl));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !hw_req[irq_idx] && !(reg_we && reg_addr == irq_idx))
      |=> !flag_vec[$past(irq_idx)]);

  // R10
  idle_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_active |-> !irq_valid);

  // R11
  trap_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |-> (trap_out && !irq_valid));

  // R12
  hold_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack && !reg_we) |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .hw_req(hw_req), .cpu_lvl(cpu_lvl),
  .trap_in(trap_in), .trap_out(trap_out), .irq_valid(irq_valid),
  .irq_ack(irq_ack), .irq_idx(irq_idx), .irq_lvl(irq_lvl),
  .arb_active(arb_active), .flag_vec(flag_vec), .en_vec(en_vec)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  localparam int N  = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [IW-1:0] reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [N-1:0]  hw_req = '0;
  logic [3:0]    cpu_lvl = '0;
  logic          trap_in = 1'b0;
  logic          trap_out;
  logic          irq_valid;
  logic          irq_ack = 1'b0;
  logic [IW-1:0] irq_idx;
  logic [3:0]    irq_lvl;
  logic [2:0]    irq_grp;
  logic          arb_active;

  int checks = 0;
  int errors = 0;
  int mreg [N];
  bit e_act, e_val;
  int e_idx, e_lvl, e_grp;

  always #2 clk = ~clk;

  irq_arbiter #(.N_SRC(N)) i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .cpu_lvl(cpu_lvl), .trap_in(trap_in), .trap_out(trap_out),
    .irq_valid(irq_valid), .irq_ack(irq_ack), .irq_idx(irq_idx),
    .irq_lvl(irq_lvl), .irq_grp(irq_grp), .arb_active(arb_active)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: best enabled pending word by (level, group), lowest index on ties
  task automatic predict();
    int best;
    e_act = 0; e_idx = 0; e_lvl = 0; e_grp = 0; best = -1;
    for (int i = 0; i < N; i++) begin
      int w, score;
      w = mreg[i];
      if (((w >> 7) & 1) == 1 && ((w >> 6) & 1) == 1) begin
        score = ((w >> 2) & 15) * 8 + ((w >> 8) & 1) * 4 + (w & 3);
        if (score > best) begin
          best = score; e_act = 1; e_idx = i;
          e_lvl = (w >> 2) & 15; e_grp = score & 7;
        end
      end
    end
    e_val = e_act && (e_lvl > int'(cpu_lvl)) && !trap_in;
  endtask

  task automatic settle();
    int rexp;
    #1;
    predict();
    rexp = (int'(reg_addr) < N) ? mreg[reg_addr] : 0;
    check("R3 rdata", int'(reg_rdata), rexp);
    check("R2 reserved", int'(reg_rdata[15:9]), 0);
    check("R10 arb_active", int'(arb_active), int'(e_act));
    check("R8 R11 irq_valid", int'(irq_valid), int'(e_val));
    check("R11 trap_out", int'(trap_out), int'(trap_in));
    if (e_act) begin
      check("R6 R7 irq_idx", int'(irq_idx), e_idx);
      check("R6 irq_lvl", int'(irq_lvl), e_lvl);
      check("R7 irq_grp", int'(irq_grp), e_grp);
    end
  endtask

  task automatic commit();
    bit hs;
    int widx;
    hs = e_val && irq_ack;
    widx = e_idx;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (reg_we && int'(reg_addr) == i) mreg[i] = int'(reg_wdata) & 'h1FF;
      if (hs && widx == i) mreg[i] = mreg[i] & ~'h80;
      if (hw_req[i]) mreg[i] = mreg[i] | 'h80;
    end
    @(negedge clk);
    reg_we = 1'b0; hw_req = '0;
  endtask

  task automatic cyc();
    settle();
    commit();
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = IW'(a); reg_wdata = 16'(d);
    cyc();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mreg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every word reads zero after reset
    for (int a = 0; a < N; a++) begin
      reg_addr = IW'(a);
      #1; check("R1 reset word", int'(reg_rdata), 0);
      cyc();
    end
    // R2 R3: write all ones, only bits 8:0 kept
    wr(0, 'hFFFF);
    reg_addr = 0; settle();
    check("R2 R3 masked write", int'(reg_rdata), 'h01FF);
    commit();
    wr(0, 0);
    // R4: hardware request sets flag
    wr(1, 'h0054);
    hw_req = 5'b00010; cyc();
    reg_addr = 1; settle();
    check("R4 flag set", int'(reg_rdata), 'h00D4);
    commit();
    // R5: disabled higher level pending source ignored
    wr(2, 'h0024);
    hw_req = 5'b00100; cyc();
    reg_addr = 2; settle();
    check("R5 disabled pending", int'(reg_rdata), 'h00A4);
    check("R5 winner", int'(irq_idx), 1);
    commit();
    // R7: group level breaks level tie, then lowest index
    wr(3, 'h01D7);
    wr(4, 'h01D7);
    settle();
    check("R7 group tie", int'(irq_idx), 3);
    commit();
    // R8: strict comparison against core level
    cpu_lvl = 4'd5; settle();
    check("R8 equal level blocked", int'(irq_valid), 0);
    commit();
    cpu_lvl = 4'd4; settle();
    check("R8 above level", int'(irq_valid), 1);
    commit();
    // R9: handshake clears winner
    cpu_lvl = 0; irq_ack = 1'b1; cyc();
    irq_ack = 1'b0; reg_addr = 3; settle();
    check("R9 cleared", int'(reg_rdata), 'h0157);
    check("R9 next winner", int'(irq_idx), 4);
    commit();
    // R9: set beats clear on same edge
    irq_ack = 1'b1; hw_req = 5'b10000; cyc();
    irq_ack = 1'b0; reg_addr = 4; settle();
    check("R9 set wins", int'(reg_rdata), 'h01D7);
    commit();
    // R12: held offer clears nothing, then a stronger source replaces it
    repeat (3) cyc();
    settle();
    check("R12 held flag", int'(reg_rdata), 'h01D7);
    check("R12 held valid", int'(irq_valid), 1);
    commit();
    wr(0, 'h00FC);
    settle();
    check("R12 offer replaced", int'(irq_idx), 0);
    commit();
    wr(0, 0);
    // R11: trap bypass
    trap_in = 1'b1; settle();
    check("R11 trap_out", int'(trap_out), 1);
    check("R11 offer masked", int'(irq_valid), 0);
    commit();
    trap_in = 1'b0;
    // R10: only disabled pending left
    wr(1, 0); wr(3, 0); wr(4, 0);
    settle();
    check("R10 idle", int'(arb_active), 0);
    check("R10 no offer", int'(irq_valid), 0);
    commit();
    // random traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      reg_we    = ($urandom_range(0, 3) == 0);
      reg_addr  = IW'($urandom_range(0, 7));
      reg_wdata = 16'($urandom);
      hw_req    = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      cpu_lvl   = 4'($urandom_range(0, 15) & ($urandom_range(0, 1) ? 4'hF : 4'h3));
      irq_ack   = ($urandom_range(0, 2) == 0);
      trap_in   = ($urandom_range(0, 15) == 0);
      cyc();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule